// File: doc/BRIEF.md
# Register Rename Status Table

This block keeps the architectural register values of a small out-of-order core together with a producer tag for each register. A tag of zero marks a register whose value is current. A nonzero tag names the execution station that will deliver the next value. Two source read ports look up operands at issue time. Each port returns either a usable value or the tag the consumer must wait for.

An issue port records the station that is assigned to a destination register. After that, later readers wait on the station rather than on the register, and this removes false write-after-read and write-after-write dependencies. A result broadcast carries a station tag and a data word. Every register still waiting on that tag takes the data and becomes ready. A single broadcast can update several registers because matching is done on the tag, not on the register index. Station numbers run from 1 upward, and tag 0 is never assigned to a station.

Top module: `rename_status_table`

## Requirements
- R1: While rst_ni is low, and after it rises, every register reads as value 0 with tag 0.
- R2: A read of a register whose tag is 0 returns the stored value with tag 0.
- R3: A read of a register whose tag is nonzero returns that tag with value 0, unless R9 applies.
- R4: An issue with iss_en_i high and a nonzero iss_tag_i sets the destination's tag from the next cycle on. A read in the same cycle sees the state before the issue.
- R5: An issue whose iss_tag_i is 0 changes nothing.
- R6: A broadcast with bc_en_i high and a nonzero bc_tag_i writes bc_data_i into every register whose tag equals bc_tag_i and clears those tags to 0 from the next cycle on. Registers with other tags keep their value and tag.
- R7: A broadcast with bc_en_i low, or with bc_tag_i equal to 0, changes nothing.
- R8: When an issue to a register happens in the same cycle as a broadcast that matches its old tag, the register ends up holding the issue tag and is not made ready.
- R9: A read of a register whose tag matches a broadcast in the same cycle returns bc_data_i with tag 0.
- R10: The two read ports work independently and may select the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_idx_i | input | IDX_W | Read port A register index |
| rd_a_val_o | output | DATA_W | Read port A value (0 while pending) |
| rd_a_tag_o | output | TAG_W | Read port A producer tag (0 when ready) |
| rd_b_idx_i | input | IDX_W | Read port B register index |
| rd_b_val_o | output | DATA_W | Read port B value (0 while pending) |
| rd_b_tag_o | output | TAG_W | Read port B producer tag (0 when ready) |
| iss_en_i | input | 1 | Issue write enable |
| iss_idx_i | input | IDX_W | Issue destination register |
| iss_tag_i | input | TAG_W | Station tag assigned at issue |
| bc_en_i | input | 1 | Result broadcast valid |
| bc_tag_i | input | TAG_W | Broadcasting station tag |
| bc_data_i | input | DATA_W | Broadcast result |

## Verification
The bench builds the table with eight registers, 16-bit data and 3-bit tags. With these values every station tag from 1 to 7 can be issued, so the test can cover two registers waiting on one tag, a station tag being reused, and the highest tag value. The 16-bit data lets each broadcast use a distinct pattern. A result that lands in the wrong register, or a broadcast that should have been ignored but lands anyway, therefore shows up in a later read.

// File: rtl/rrt_entry.sv
module rrt_entry #(
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int IDX_W    = 3,
  parameter int SELF_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_en_i,
  input  logic [IDX_W-1:0]  iss_idx_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic              bc_en_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] val_o
);
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] val_q;
  logic              iss_hit, bc_hit;

  assign iss_hit = iss_en_i && (iss_idx_i == IDX_W'(SELF_IDX)) && (iss_tag_i != '0);
  assign bc_hit  = bc_en_i && (tag_q != '0) && (bc_tag_i == tag_q);

  // issue has priority over a broadcast matching the old tag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (iss_hit) begin
      tag_q <= iss_tag_i;
    end else if (bc_hit) begin
      tag_q <= '0;
      val_q <= bc_data_i;
    end
  end

  assign tag_o = tag_q;
  assign val_o = val_q;

  assert_issue_tag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_hit |=> tag_o == $past(iss_tag_i));

  assert_issue_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_hit && bc_en_i && bc_tag_i == tag_o && tag_o != '0) |=> tag_o != '0);

  assert_bcast_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_hit && !iss_hit) |=> (tag_o == '0) && (val_o == $past(bc_data_i)));

  // covers R5 (tag-0 issue) as well
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iss_en_i && iss_idx_i == IDX_W'(SELF_IDX) && iss_tag_i != '0) &&
    !(bc_en_i && bc_tag_i != '0 && bc_tag_i == tag_o)
    |=> $stable(tag_o) && $stable(val_o));
endmodule

// File: rtl/rrt_read_port.sv
module rrt_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int IDX_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  vals_i,
  input  logic                             bc_en_i,
  input  logic [TAG_W-1:0]                 bc_tag_i,
  input  logic [DATA_W-1:0]                bc_data_i,
  output logic [DATA_W-1:0]                val_o,
  output logic [TAG_W-1:0]                 tag_o
);
  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_tag = tags_i[idx_i];
    sel_val = vals_i[idx_i];
    if (sel_tag == '0) begin
      val_o = sel_val;
      tag_o = '0;
    end else if (bc_en_i && bc_tag_i == sel_tag) begin
      val_o = bc_data_i;  // same-cycle bypass
      tag_o = '0;
    end else begin
      val_o = '0;
      tag_o = sel_tag;
    end
  end

  assert_pending_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o != '0 |-> val_o == '0);

  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_en_i && bc_tag_i != '0) |-> tag_o != bc_tag_i);
endmodule

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_val_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_val_o,
  output logic [TAG_W-1:0]  rd_b_tag_o,
  input  logic              iss_en_i,
  input  logic [IDX_W-1:0]  iss_idx_i,
  input  logic [TAG_W-1:0]  iss_tag_i,
  input  logic              bc_en_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_data_i
);
  logic [NUM_REGS-1:0][TAG_W-1:0]  tags;
  logic [NUM_REGS-1:0][DATA_W-1:0] vals;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    rrt_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .SELF_IDX(g)
    ) entry_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .iss_en_i(iss_en_i), .iss_idx_i(iss_idx_i), .iss_tag_i(iss_tag_i),
      .bc_en_i(bc_en_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
      .tag_o(tags[g]), .val_o(vals[g])
    );
  end

  rrt_read_port #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) port_a_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(rd_a_idx_i),
    .tags_i(tags), .vals_i(vals),
    .bc_en_i(bc_en_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
    .val_o(rd_a_val_o), .tag_o(rd_a_tag_o)
  );

  rrt_read_port #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) port_b_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(rd_b_idx_i),
    .tags_i(tags), .vals_i(vals),
    .bc_en_i(bc_en_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
    .val_o(rd_b_val_o), .tag_o(rd_b_tag_o)
  );

  assert_ports_agree_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_idx_i == rd_b_idx_i) |-> (rd_a_val_o == rd_b_val_o) && (rd_a_tag_o == rd_b_tag_o));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (rd_a_tag_o == '0 && rd_b_tag_o == '0);
    end
  end
endmodule

// File: tb/rename_status_table_tb_top.sv
module rename_status_table_tb_top;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [3:0]  req;
    logic        ie;
    logic [2:0]  ii;
    logic [2:0]  it;
    logic        be;
    logic [2:0]  bt;
    logic [15:0] bd;
    logic [2:0]  ra;
    logic [2:0]  rb;
    logic [15:0] eav;
    logic [2:0]  eat;
    logic [15:0] ebv;
    logic [2:0]  ebt;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  1'b0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 3'd1,3'd2, 16'h0000,3'd0, 16'h0000,3'd0}, // R1 idle after reset
    '{4'd4,  1'b1,3'd1,3'd3, 1'b0,3'd0,16'h0000, 3'd1,3'd1, 16'h0000,3'd0, 16'h0000,3'd0}, // R4 same-cycle read sees old, R10
    '{4'd3,  1'b1,3'd2,3'd3, 1'b0,3'd0,16'h0000, 3'd1,3'd2, 16'h0000,3'd3, 16'h0000,3'd0}, // R3 pending read
    '{4'd9,  1'b1,3'd5,3'd6, 1'b1,3'd3,16'h1234, 3'd1,3'd2, 16'h1234,3'd0, 16'h1234,3'd0}, // R9 bypass
    '{4'd6,  1'b0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 3'd1,3'd5, 16'h1234,3'd0, 16'h0000,3'd6}, // R6 multi-fill, R2
    '{4'd7,  1'b1,3'd4,3'd0, 1'b1,3'd0,16'hdead, 3'd4,3'd2, 16'h0000,3'd0, 16'h1234,3'd0}, // R5/R7 zero tags
    '{4'd5,  1'b0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 3'd4,3'd5, 16'h0000,3'd0, 16'h0000,3'd6}, // R5 issue tag 0 ignored
    '{4'd8,  1'b1,3'd5,3'd2, 1'b1,3'd6,16'h0bad, 3'd5,3'd2, 16'h0bad,3'd0, 16'h1234,3'd0}, // R8 collide, R7 dead not landed
    '{4'd8,  1'b0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 3'd5,3'd1, 16'h0000,3'd2, 16'h1234,3'd0}, // R8 issue won
    '{4'd7,  1'b0,3'd0,3'd0, 1'b0,3'd2,16'h5555, 3'd5,3'd7, 16'h0000,3'd2, 16'h0000,3'd0}, // R7 bc_en low
    '{4'd9,  1'b0,3'd0,3'd0, 1'b1,3'd2,16'h7777, 3'd5,3'd5, 16'h7777,3'd0, 16'h7777,3'd0}, // R9 bypass, R10
    '{4'd6,  1'b0,3'd0,3'd0, 1'b0,3'd0,16'h0000, 3'd5,3'd1, 16'h7777,3'd0, 16'h1234,3'd0}  // R6 filled
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, iss_idx_i = '0, iss_tag_i = '0, bc_tag_i = '0;
  logic        iss_en_i = 1'b0, bc_en_i = 1'b0;
  logic [15:0] bc_data_i = '0;
  logic [15:0] rd_a_val_o, rd_b_val_o;
  logic [2:0]  rd_a_tag_o, rd_b_tag_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  rename_status_table #(.NUM_REGS(8), .DATA_W(16), .TAG_W(3)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_a_idx_i(rd_a_idx_i), .rd_a_val_o(rd_a_val_o), .rd_a_tag_o(rd_a_tag_o),
    .rd_b_idx_i(rd_b_idx_i), .rd_b_val_o(rd_b_val_o), .rd_b_tag_o(rd_b_tag_o),
    .iss_en_i(iss_en_i), .iss_idx_i(iss_idx_i), .iss_tag_i(iss_tag_i),
    .bc_en_i(bc_en_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i)
  );

  task automatic check(input string req, input logic [15:0] av, input logic [2:0] at,
                       input logic [15:0] ev, input logic [2:0] et);
    checks++;
    if (av !== ev || at !== et) begin
      failures++;
      $display("FAIL %s: got val=%h tag=%0d, expected val=%h tag=%0d", req, av, at, ev, et);
    end
  endtask

  task automatic idle_inputs();
    iss_en_i = 1'b0; iss_idx_i = '0; iss_tag_i = '0;
    bc_en_i = 1'b0; bc_tag_i = '0; bc_data_i = '0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: values during reset
    repeat (2) @(negedge clk_i);
    rd_a_idx_i = 3'd0; rd_b_idx_i = 3'd7;
    #2;
    check("R1 in reset", rd_a_val_o, rd_a_tag_o, 16'h0, 3'd0);
    check("R1 in reset", rd_b_val_o, rd_b_tag_o, 16'h0, 3'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk_i);
      iss_en_i = VECS[v].ie; iss_idx_i = VECS[v].ii; iss_tag_i = VECS[v].it;
      bc_en_i = VECS[v].be; bc_tag_i = VECS[v].bt; bc_data_i = VECS[v].bd;
      rd_a_idx_i = VECS[v].ra; rd_b_idx_i = VECS[v].rb;
      #2;
      check($sformatf("R%0d vec %0d port a", VECS[v].req, v), rd_a_val_o, rd_a_tag_o, VECS[v].eav, VECS[v].eat);
      check($sformatf("R%0d vec %0d port b", VECS[v].req, v), rd_b_val_o, rd_b_tag_o, VECS[v].ebv, VECS[v].ebt);
    end

    // R4: highest tag value on register 3
    @(negedge clk_i);
    idle_inputs();
    iss_en_i = 1'b1; iss_idx_i = 3'd3; iss_tag_i = 3'd7;
    @(negedge clk_i);
    idle_inputs();
    rd_a_idx_i = 3'd3; rd_b_idx_i = 3'd0;
    #2;
    check("R4 tag 7", rd_a_val_o, rd_a_tag_o, 16'h0, 3'd7);
    check("R2 reg0 ready", rd_b_val_o, rd_b_tag_o, 16'h0, 3'd0);

    // R1: reset mid-run clears pending tags and values
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int r = 0; r < 8; r++) begin
      rd_a_idx_i = 3'(r); rd_b_idx_i = 3'(7 - r);
      #1;
      check($sformatf("R1 after reset reg %0d", r), rd_a_val_o, rd_a_tag_o, 16'h0, 3'd0);
      check($sformatf("R1 after reset reg %0d", 7 - r), rd_b_val_o, rd_b_tag_o, 16'h0, 3'd0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule